// File: doc/BRIEF.md
# Destination address hash filter

This block sits on the receive path of an Ethernet MAC. It takes the destination address of an incoming frame, one byte per accepted strobe in the order the bytes arrive on the wire, and decides whether the frame should be kept. The decision comes from a 64-entry hash table. The six address bytes are folded into a 6-bit index, and the index picks one bit of that table.

The host loads the table as two 32-bit halves and supplies three configuration levels:
- a hash enable for group (multicast) addresses;
- a hash enable for individual (unicast) addresses;
- a copy-all override that accepts every frame.

The block reports a decision flag, a match flag and a group flag. These stay stable until the next frame begins. Exact-address comparison and frame check sequence handling belong to other blocks.

Top module: `addr_hash_filter`

## Requirements
- R1: After reset, `match_valid`, `match` and `match_mcast` are 0 and every hash table bit is 0, so no frame matches through the hash until the host writes the table.
- R2: The first byte accepted after `frame_start` supplies address bits 7..0, the second supplies bits 15..8, and so on up to the sixth byte, which supplies bits 47..40. Address bit 0 is the group bit, and `match_mcast` reports its value.
- R3: Index bit j (0..5) is the XOR of address bits j, j+6, j+12, j+18, j+24, j+30, j+36 and j+42.
- R4: Index values 0..31 select bit `index` of the low half. Index values 32..63 select bit `index-32` of the high half.
- R5: A host write with `cfg_wr_sel`=0 replaces the whole low half with `cfg_wr_data`. A host write with `cfg_wr_sel`=1 replaces the whole high half. The write takes effect at the clock edge on which `cfg_wr_en` is high.
- R6: With `copy_all` low, a group address (bit 0 = 1) matches exactly when `mc_hash_en` is 1 and the indexed table bit is 1. In this case `uc_hash_en` has no effect.
- R7: With `copy_all` low, an individual address (bit 0 = 0) matches exactly when `uc_hash_en` is 1 and the indexed table bit is 1. In this case `mc_hash_en` has no effect.
- R8: With `copy_all` high, every frame matches, whatever the table contents and the enables.
- R9: `match_valid` rises at the clock edge that accepts the sixth address byte, so it is visible in the following cycle. It stays high until `frame_start`, which clears it at that same edge.
- R10: Bytes presented after the sixth byte and before the next `frame_start` are ignored, and the held decision does not change.
- R11: Configuration and table changes made after a decision has been registered do not alter that decision.
- R12: While `match_valid` is 0, `match` and `match_mcast` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Host write strobe for the hash table |
| cfg_wr_sel | input | 1 | Selects the half to write: 0 low, 1 high |
| cfg_wr_data | input | 32 | Value written into the selected half |
| mc_hash_en | input | 1 | Enables hash matching of group addresses |
| uc_hash_en | input | 1 | Enables hash matching of individual addresses |
| copy_all | input | 1 | Accepts every frame |
| frame_start | input | 1 | Starts a new frame and clears the held decision |
| byte_valid | input | 1 | Qualifies `byte_data` |
| byte_data | input | 8 | Destination address byte, in arrival order |
| match_valid | output | 1 | A decision is held |
| match | output | 1 | The frame is accepted |
| match_mcast | output | 1 | The destination is a group address |

## Verification
The first sweep covers every one of the 64 index values. For each one, the bench alters a base address until the bench-computed fold equals the wanted index. It then loads a one-hot table, which must match, and its complement, which must not. This separates a wrong fold or a swapped half from a correct lookup. A second sweep tries every combination of the two enables and copy-all, against group and individual addresses, with the indexed bit set and with it clear. This shows whether each enable is gated by the group bit. Directed frames probe the decision cycle, the clear on `frame_start`, the bytes after the sixth, and configuration changes made after the decision.

// File: rtl/addr_hash_filter.sv
module addr_hash_filter #(
  parameter int ADDR_BYTES = 6,
  parameter int IDX_W      = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_wr_en,
  input  logic                       cfg_wr_sel,
  input  logic [(1<<IDX_W)/2-1:0]    cfg_wr_data,
  input  logic                       mc_hash_en,
  input  logic                       uc_hash_en,
  input  logic                       copy_all,
  input  logic                       frame_start,
  input  logic                       byte_valid,
  input  logic [7:0]                 byte_data,
  output logic                       match_valid,
  output logic                       match,
  output logic                       match_mcast
);
  localparam int AW    = ADDR_BYTES * 8;
  localparam int TBL   = 1 << IDX_W;
  localparam int HALF  = TBL / 2;
  localparam int CW    = $clog2(ADDR_BYTES + 1);
  localparam int FOLDS = (AW + IDX_W - 1) / IDX_W;

  logic [AW-1:0]    addr_q, addr_nx;
  logic [CW-1:0]    cnt_q, pos;
  logic [TBL-1:0]   hash_q;
  logic [IDX_W-1:0] idx;
  logic             take, last, hit, grp, decide;
  logic             valid_q, match_q, mcast_q;

  assign pos  = frame_start ? '0 : cnt_q;
  assign take = byte_valid && (frame_start || cnt_q < CW'(ADDR_BYTES));
  assign last = take && pos == CW'(ADDR_BYTES - 1);

  always_comb begin
    addr_nx = frame_start ? '0 : addr_q;
    if (take) addr_nx[pos*8 +: 8] = byte_data;
  end

  always_comb begin
    idx = '0;
    for (int k = 0; k < FOLDS; k++)
      for (int j = 0; j < IDX_W; j++)
        if (j + IDX_W * k < AW) idx[j] = idx[j] ^ addr_nx[j + IDX_W * k];
  end

  assign hit    = hash_q[idx];
  assign grp    = addr_nx[0];
  assign decide = copy_all | (hit & (grp ? mc_hash_en : uc_hash_en));

  genvar h;
  generate
    for (h = 0; h < 2; h++) begin : g_half
      always_ff @(posedge clk) begin
        if (!rst_n) hash_q[h*HALF +: HALF] <= '0;
        else if (cfg_wr_en && cfg_wr_sel == 1'(h)) hash_q[h*HALF +: HALF] <= cfg_wr_data;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      cnt_q   <= '0;
      valid_q <= 1'b0;
      match_q <= 1'b0;
      mcast_q <= 1'b0;
    end else begin
      if (take) begin
        addr_q <= addr_nx;
        cnt_q  <= pos + 1'b1;
      end else if (frame_start) begin
        addr_q <= '0;
        cnt_q  <= '0;
      end
      if (last) begin
        valid_q <= 1'b1;
        match_q <= decide;
        mcast_q <= grp;
      end else if (frame_start) begin
        valid_q <= 1'b0;
        match_q <= 1'b0;
        mcast_q <= 1'b0;
      end
    end
  end

  assign match_valid = valid_q;
  assign match       = match_q;
  assign match_mcast = mcast_q;
endmodule

// File: rtl/addr_hash_filter_chk.sv
module addr_hash_filter_chk #(
  parameter int HALF = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_start,
  input logic              cfg_wr_en,
  input logic              cfg_wr_sel,
  input logic [HALF-1:0]   cfg_wr_data,
  input logic [2*HALF-1:0] hash_q,
  input logic              copy_all,
  input logic              match_valid,
  input logic              match,
  input logic              match_mcast
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !match_valid |-> (!match && !match_mcast)); // R12
  AST_CLEAR_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !match_valid); // R9
  AST_HOLD_DECISION: assert property (@(posedge clk) disable iff (!rst_n)
    (match_valid && !frame_start) |=> (match_valid && $stable(match) && $stable(match_mcast))); // R10
  AST_COPY_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(match_valid) && $past(copy_all)) |-> match); // R8
  AST_LOW_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_en && !cfg_wr_sel) |=> hash_q[HALF-1:0] == $past(cfg_wr_data)); // R5
  AST_HIGH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_en && cfg_wr_sel) |=> hash_q[2*HALF-1:HALF] == $past(cfg_wr_data)); // R5
endmodule

bind addr_hash_filter addr_hash_filter_chk #(.HALF(HALF)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
  .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel), .cfg_wr_data(cfg_wr_data),
  .hash_q(hash_q), .copy_all(copy_all),
  .match_valid(match_valid), .match(match), .match_mcast(match_mcast)
);

// File: tb/sim_addr_hash_filter.sv
`timescale 1ns/1ps
module sim_addr_hash_filter;
  logic clk = 0, rst_n = 0;
  logic cfg_wr_en = 0, cfg_wr_sel = 0;
  logic [31:0] cfg_wr_data = '0;
  logic mc_hash_en = 0, uc_hash_en = 0, copy_all = 0;
  logic frame_start = 0, byte_valid = 0;
  logic [7:0] byte_data = '0;
  logic match_valid, match, match_mcast;
  int checks = 0, errors = 0, cyc = 0;

  always #2 clk = ~clk;

  addr_hash_filter u0 (.*);

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: act=%0d exp=<150000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] fold(input logic [47:0] a);
    logic [5:0] r = '0;
    for (int b = 0; b < 48; b++) r[b % 6] ^= a[b];
    return r;
  endfunction

  task automatic load_table(input logic [63:0] t);
    @(negedge clk); cfg_wr_en = 1; cfg_wr_sel = 0; cfg_wr_data = t[31:0];
    @(negedge clk); cfg_wr_sel = 1; cfg_wr_data = t[63:32];
    @(negedge clk); cfg_wr_en = 0;
  endtask

  task automatic send(input logic [47:0] a);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); frame_start = (k == 0); byte_valid = 1; byte_data = a[8*k +: 8];
    end
    @(negedge clk); frame_start = 0; byte_valid = 0;
  endtask

  function automatic logic [47:0] aim(input logic [47:0] base, input logic [5:0] want);
    logic [47:0] a = base;
    a[5:0] = a[5:0] ^ (fold(base) ^ want);
    return a;
  endfunction

  initial begin
    logic [47:0] a, b;
    logic [5:0] ix;
    logic [63:0] oh;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 valid after reset", match_valid, 0);
    check("R1 match after reset", match, 0);
    mc_hash_en = 1; uc_hash_en = 1;
    send(48'h0123_4567_89AB);
    check("R1 empty table no match", match, 0);
    check("R12 mcast reported R2", match_mcast, 1);

    for (int i = 0; i < 64; i++) begin
      a = aim(48'hA5C3_1E77_9B40 ^ (48'h0003_1F2B_7C91 * i), i[5:0]);
      ix = fold(a);
      oh = 64'd1 << ix;
      load_table(oh);
      send(a);
      check("R3 R4 one-hot hit", {match_valid, match}, 2'b11);
      check("R2 group bit", match_mcast, a[0]);
      load_table(~oh);
      send(a);
      check("R3 R4 R5 complement miss", match, 0);
    end

    for (int m = 0; m < 8; m++)
      for (int g = 0; g < 2; g++)
        for (int hb = 0; hb < 2; hb++) begin
          a = aim(48'h5A3C_D2E1_F046, 6'd37);
          a[0] = g[0];
          a = aim(a, 6'd37);
          if (a[0] != g[0]) a = aim(a ^ 48'h41, 6'd37);
          ix = fold(a);
          load_table(hb ? (64'd1 << ix) : 64'd0);
          mc_hash_en = m[0]; uc_hash_en = m[1]; copy_all = m[2];
          send(a);
          check(g ? "R6 R8 group enable" : "R7 R8 individual enable", match,
                m[2] | (hb[0] & (a[0] ? m[0] : m[1])));
        end

    copy_all = 0; mc_hash_en = 1; uc_hash_en = 1;
    a = aim(48'h1111_2222_3334, 6'd12);
    load_table(64'd1 << fold(a));
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); frame_start = (k == 0); byte_valid = 1; byte_data = a[8*k +: 8];
      if (k == 5) check("R9 not valid before sixth byte", match_valid, 0);
    end
    @(negedge clk); frame_start = 0;
    check("R9 valid after sixth byte", {match_valid, match}, 2'b11);
    b = ~a;
    for (int k = 0; k < 4; k++) begin byte_data = b[8*k +: 8]; @(negedge clk); end
    byte_valid = 0;
    check("R10 extra bytes ignored", {match_valid, match, match_mcast}, {2'b11, a[0]});
    mc_hash_en = 0; uc_hash_en = 0;
    load_table(64'd0);
    check("R11 held after config change", {match_valid, match}, 2'b11);
    @(negedge clk); frame_start = 1;
    @(negedge clk); frame_start = 0;
    check("R9 frame_start clears", match_valid, 0);
    check("R12 quiet when not valid", {match, match_mcast}, 2'b00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule